// File: doc/BRIEF.md
# Peripheral Idle Timer With Access Trap

This block is one power-management channel for a single peripheral. It watches every bus cycle against a programmable address window and keeps an idle countdown. The countdown runs on an external once-per-second strobe. Any access that lands in the window reloads the countdown from a software-programmed value. If the countdown runs out, the channel records a timeout cause, provided power management is globally enabled. Software can also arm a trap. With the trap armed, the next access to the window records a trap cause instead.

Both causes are sticky status bits, and software clears them by writing ones. The channel's SMI request is high whenever any cause bit is set. The usual flow has two phases. When the timeout fires, the handler powers the peripheral down, stops the timer and arms the trap. When the trap fires, the handler powers the peripheral back up, restarts the timer and disarms the trap.

Configuration goes through a simple write port with a 3-bit register select. The window can cover I/O space or memory space. It is defined by a base address and a don't-care mask.

Top module: `idle_trap_chan`

## Requirements
- R1: While the timer is enabled, each cycle with `tick` high and no window hit lowers a nonzero count by exactly one. A timeout of N is signalled on the N-th tick after loading.
- R2: The count does not change in these cases: the timer is disabled; the count is zero; or no tick and no hit occur. After expiry the count stays at zero and raises no further timeout cause until it is reloaded.
- R3: While the timer is enabled, a window hit reloads the count from the reload register. This also holds when `tick` is high in the same cycle.
- R4: A tick that takes the count from 1 to 0 sets status bit 0 (timeout) on the next edge when `pm_en` is high.
- R5: When `pm_en` is low at expiry, status bit 0 stays clear.
- R6: A window hit requires `bus_valid`, and `bus_is_mem` must equal the control space bit. It also requires `(bus_addr & ~mask) == (base & ~mask)`.
- R7: When the trap is enabled (control bit 1), a window hit sets status bit 1 (trap). When the trap is disabled, a hit leaves the status unchanged.
- R8: Status bits hold until a write to select 4 with a 1 in the bit's position. A cause that is set in the same cycle as its clear stays set.
- R9: `smi_req` is high exactly when any status bit is set. After reset, status, count and `smi_req` are all zero.
- R10: The register selects are: 0 reload value (also loads the count), 1 base, 2 mask, 3 control, 4 status clear. The control bits are: bit 0 timer enable, bit 1 trap enable, bit 2 memory space. Writing control with bit 0 set while the timer is off loads the count from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| pm_en | input | 1 | Global power-management enable |
| bus_valid | input | 1 | A bus cycle is present |
| bus_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| bus_addr | input | AW | Bus cycle address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | DW | Register write data |
| idle_cnt | output | CW | Current idle count |
| smi_stat | output | 2 | Sticky causes: bit 0 timeout, bit 1 trap |
| smi_req | output | 1 | SMI request, the OR of the status bits |

## Verification
A wrong window compare shows up one edge after the offending bus cycle. It appears as a trap bit that should or should not be set, and as a count that did or did not jump back to the reload value. A count that is off by one, or that decrements when it should not, appears on `idle_cnt` at the next sample. It also moves the timeout bit by a whole tick. A broken sticky or clear path appears on `smi_stat` and `smi_req` one edge after the write or the event.

// File: rtl/idle_trap_chan.sv
module idle_trap_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pm_en,
  input  logic          bus_valid,
  input  logic          bus_is_mem,
  input  logic [AW-1:0] bus_addr,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] idle_cnt,
  output logic [1:0]    smi_stat,
  output logic          smi_req
);

  localparam logic [2:0] SEL_RELOAD = 3'd0;
  localparam logic [2:0] SEL_BASE   = 3'd1;
  localparam logic [2:0] SEL_MASK   = 3'd2;
  localparam logic [2:0] SEL_CTRL   = 3'd3;
  localparam logic [2:0] SEL_STAT   = 3'd4;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] reload_q, cnt_q, cnt_nxt;
  logic [AW-1:0] base_q, mask_q;
  logic          timer_en_q, trap_en_q, mem_q;
  logic [1:0]    stat_q, stat_set, stat_clr;
  logic          hit, expire;

  wire wr_reload = wr_en && (wr_sel == SEL_RELOAD);
  wire wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  wire wr_stat   = wr_en && (wr_sel == SEL_STAT);
  wire start     = wr_ctrl && wr_data[0] && !timer_en_q;

  assign hit = bus_valid && (bus_is_mem == mem_q) &&
               (((bus_addr ^ base_q) & ~mask_q) == '0);

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_reload)
      cnt_nxt = wr_data[CW-1:0];
    else if (start)
      cnt_nxt = reload_q;
    else if (timer_en_q) begin
      if (hit)
        cnt_nxt = reload_q;
      else if (tick && cnt_q != '0)
        cnt_nxt = cnt_q - CNT_ONE;
    end
  end

  assign expire   = (cnt_q == CNT_ONE) && (cnt_nxt == '0);
  assign stat_set = {trap_en_q && hit, expire && pm_en};
  assign stat_clr = wr_stat ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q   <= '0;
      base_q     <= '0;
      mask_q     <= '0;
      timer_en_q <= 1'b0;
      trap_en_q  <= 1'b0;
      mem_q      <= 1'b0;
      cnt_q      <= '0;
      stat_q     <= '0;
    end else begin
      if (wr_reload) reload_q <= wr_data[CW-1:0];
      if (wr_en && wr_sel == SEL_BASE) base_q <= wr_data[AW-1:0];
      if (wr_en && wr_sel == SEL_MASK) mask_q <= wr_data[AW-1:0];
      if (wr_ctrl) begin
        timer_en_q <= wr_data[0];
        trap_en_q  <= wr_data[1];
        mem_q      <= wr_data[2];
      end
      cnt_q  <= cnt_nxt;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  assign idle_cnt = cnt_q;
  assign smi_stat = stat_q;
  assign smi_req  = |stat_q;

endmodule

// File: rtl/idle_trap_chan_chk.sv
module idle_trap_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pm_en,
  input logic          wr_en,
  input logic          hit,
  input logic          timer_en_q,
  input logic          trap_en_q,
  input logic [CW-1:0] reload_q,
  input logic [CW-1:0] cnt_q,
  input logic [1:0]    stat_q,
  input logic          smi_req,
  input logic [2:0]    wr_sel,
  input logic [1:0]    clr_bits
);

  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_en_q && tick && !hit && cnt_q != '0 && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en_q && !wr_en) |=> $stable(cnt_q)); // R2

  AST_HIT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_en_q && hit && !wr_en) |=> (cnt_q == $past(reload_q))); // R3

  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_en_q && tick && !hit && cnt_q == CW'(1) && pm_en && !wr_en) |=> stat_q[0]); // R4

  AST_GATED_BY_PM: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_en && !stat_q[0]) |=> !stat_q[0]); // R5

  AST_TRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en_q && hit) |=> stat_q[1]); // R7

  AST_STICKY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !(wr_en && wr_sel == 3'd4 && clr_bits[1])) |=> stat_q[1]); // R8

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> $past(stat_q) == 2'b00); // R9

endmodule

bind idle_trap_chan idle_trap_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pm_en(pm_en), .wr_en(wr_en),
  .hit(hit), .timer_en_q(timer_en_q), .trap_en_q(trap_en_q),
  .reload_q(reload_q), .cnt_q(cnt_q), .stat_q(stat_q), .smi_req(smi_req),
  .wr_sel(wr_sel), .clr_bits(wr_data[1:0])
);

// File: tb/idle_trap_chan_test.sv
module idle_trap_chan_test;
  localparam int AW = 8, CW = 16, DW = 32;

  logic clk = 0, rst_n = 0, tick = 0, pm_en = 0;
  logic bus_valid = 0, bus_is_mem = 0, wr_en = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] idle_cnt;
  logic [1:0] smi_stat;
  logic smi_req;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  idle_trap_chan #(.AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pm_en(pm_en),
    .bus_valid(bus_valid), .bus_is_mem(bus_is_mem), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .idle_cnt(idle_cnt), .smi_stat(smi_stat), .smi_req(smi_req));

  task automatic check(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 3'(sel); wr_data = DW'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus(int addr, bit mem, bit tk);
    bus_valid = 1; bus_addr = AW'(addr); bus_is_mem = mem; tick = tk;
    @(negedge clk);
    bus_valid = 0; tick = 0;
  endtask

  task automatic pulse();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int masks[4] = '{8'h00, 8'h0F, 8'h03, 8'hF0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset stat", smi_stat, 0);
    check("R9 reset req", smi_req, 0);
    check("R9 reset cnt", idle_cnt, 0);

    // R6/R7 decode sweep with the trap armed
    wr(1, 8'hA5);
    for (int m = 0; m < 4; m++) begin
      wr(2, masks[m]);
      for (int rm = 0; rm < 2; rm++) begin
        wr(3, 2 | (rm << 2));
        for (int a = 0; a < 256; a++) begin
          for (int t = 0; t < 2; t++) begin
            bit e;
            e = (t == rm) && ((((a ^ 8'hA5) & ~masks[m]) & 8'hFF) == 0);
            bus(a, bit'(t), 0);
            check("R6 R7 trap decode", smi_stat, e ? 2 : 0);
            check("R9 req", smi_req, int'(e));
            if (e) begin
              wr(4, 2);
              check("R8 clear", smi_stat, 0);
            end
          end
        end
      end
    end

    // R7 trap disabled: no effect
    wr(2, 0); wr(3, 0);
    bus(8'hA5, 0, 0);
    check("R7 trap off", smi_stat, 0);

    // R1/R4/R2 countdown with power management on
    pm_en = 1;
    wr(3, 1);
    for (int v = 1; v <= 6; v++) begin
      wr(0, v);
      check("R10 load", idle_cnt, v);
      for (int k = 1; k <= v; k++) begin
        pulse();
        check("R1 count", idle_cnt, v - k);
        check("R4 expire", smi_stat, (k == v) ? 1 : 0);
      end
      wr(4, 1);
      pulse(); pulse();
      check("R2 stop at zero", idle_cnt, 0);
      check("R2 no repeat", smi_stat, 0);
    end
    // no tick: count holds
    wr(0, 4);
    @(negedge clk); @(negedge clk);
    check("R2 no tick hold", idle_cnt, 4);

    // R5 pm gating
    pm_en = 0;
    wr(0, 2);
    pulse(); pulse();
    check("R5 cnt", idle_cnt, 0);
    check("R5 no set", smi_stat, 0);
    check("R9 no req", smi_req, 0);
    pm_en = 1;

    // R3 reload on hit, priority over tick
    wr(1, 8'h40);
    wr(0, 5);
    pulse(); pulse();
    check("R1 partial", idle_cnt, 3);
    bus(8'h40, 0, 0);
    check("R3 hit reload", idle_cnt, 5);
    pulse();
    bus(8'h40, 0, 1);
    check("R3 hit beats tick", idle_cnt, 5);
    bus(8'h41, 0, 1);
    check("R6 miss decrements", idle_cnt, 4);
    bus(8'h40, 1, 1);
    check("R6 wrong space", idle_cnt, 3);

    // R2 disabled holds; R10 re-enable reloads
    wr(3, 0);
    pulse();
    bus(8'h40, 0, 0);
    check("R2 disabled hold", idle_cnt, 3);
    wr(3, 1);
    check("R10 enable reload", idle_cnt, 5);

    // R8 set wins over clear in the same cycle
    wr(3, 2);
    bus_valid = 1; bus_addr = 8'h40; bus_is_mem = 0;
    wr(4, 2);
    bus_valid = 0;
    check("R8 set beats clear", smi_stat, 2);
    @(negedge clk);
    check("R8 sticky", smi_stat, 2);
    wr(4, 1);
    check("R8 other bit clear", smi_stat, 2);
    wr(4, 2);
    check("R8 w1c", smi_stat, 0);
    check("R9 req low", smi_req, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule